// File: doc/BRIEF.md
# Lockable GPIO Port Registers

This block is the register side of a 16-pin general-purpose I/O port. A 32-bit register bus with separate write and read strobes reaches two configuration registers, each holding eight 4-bit per-pin fields. It also reaches an output data register, an input data register fed from synchronized pins, an atomic set/clear register, a clear-only register and a lock register. The block decodes each pin's field into output enable, output value, open-drain and pull controls for a pad model.

The lock register guards the configuration against stray writes. A key sequence of three writes followed by one read freezes the configuration fields of the pins named in a mask until the next reset. The output data register stays writable, so locked output pins can still be driven. Read data is combinational from the address, and a write takes effect at the clock edge on which `we_i` is high.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset every pin's 4-bit field reads 4 (input, floating), output data reads 0, the lock register reads 0, and all pad controls are 0.
- R2: Word address 0 holds the fields of pins 0 to 7 and word address 1 holds pins 8 to 15. Each field sits at bit 4*(pin mod 8), with mode in bits [1:0] and type in bits [3:2], and reads back as written.
- R3: A nonzero mode selects output. The pin's output enable is then 1, its output value equals its output data bit, and open-drain is type bit 0 (types 01 and 11). In input mode, output enable, output value and open-drain are all 0.
- R4: In input mode with type 10, pull enable is 1 and pull-up equals the pin's output data bit (1 = up, 0 = down). Every other input type and every output mode gives pull enable 0 and pull-up 0.
- R5: Word address 3 is the output data register. Bits [15:0] are written directly and read back, and the upper bits read 0.
- R6: A write to word address 4 sets the output bits where bits [15:0] are 1 and clears them where bits [31:16] are 1. Zero bits leave their pins untouched, and a pin with both bits at 1 is set. The address reads 0.
- R7: A write to word address 5 clears the output bits where bits [15:0] are 1 and leaves the rest unchanged. The address reads 0.
- R8: Word address 2 returns the pin levels in bits [15:0]. A level change is visible after exactly two clock edges and not after one, and writes to this address have no effect.
- R9: The lock register is word address 6, with the key at bit 16 and the mask at bits [15:0]. Writing key=1, then key=0, then key=1 with the same mask, followed by a read of address 6, activates the lock. The read that completes the sequence returns key 0, and later reads return key 1 with the mask.
- R10: While the lock is active, writes leave the fields of masked pins unchanged. The fields of unmasked pins and the output data stay writable.
- R11: A lock write that breaks the sequence (a wrong key value or a changed mask) restarts it. If the breaking write has key=1, it counts as a new first step. A read before the third write does not lock.
- R12: Once the lock is active, writes to address 6 change neither the key nor the mask. Only reset releases the lock.
- R13: Address 7 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (advances the lock sequence) |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | 16 | Pin levels from the pads, asynchronous |
| pad_out_o | output | 16 | Per-pin output value |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_od_o | output | 16 | Per-pin open-drain select |
| pad_pull_en_o | output | 16 | Per-pin pull enable |
| pad_pull_up_o | output | 16 | Per-pin pull direction, 1 = up |

## Verification
Directed patterns write one field per pin so that each mode and type value lands in a known slot, which separates a field-offset error from a decode error. A set/clear word with both halves set on the same pin tells set priority from clear priority, and mixed zero bits show whether other pins are disturbed. The lock is driven with a complete sequence, with a changed mask, and with a premature read, so that a correct sequence is separated from near misses. A seeded random mix of field, data, set/clear, clear-only and lock writes is then compared against a bench model, both before and after the lock is active.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int N_PINS    = 16;
  localparam int FIELD_W   = 4;
  localparam int PER_WORD  = 32 / FIELD_W;
  localparam int ADDR_W    = 3;
  localparam int KEY_BIT   = 16;

  localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_IN     = 3'd2;
  localparam logic [ADDR_W-1:0] A_OUT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;
  localparam logic [ADDR_W-1:0] A_LOCK   = 3'd6;

  localparam logic [FIELD_W-1:0] FIELD_RST = 4'h4;
  localparam logic [1:0]         TYPE_PULL = 2'b10;

  typedef enum logic [1:0] {LK_IDLE, LK_ARM1, LK_ARM0, LK_WAIT_RD} lk_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int NP = N_PINS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          key_i,
  input  logic [NP-1:0] mask_i,
  output logic          locked_o,
  output logic [NP-1:0] mask_o
);
  lk_state_e     st_q;
  logic [NP-1:0] mask_q;
  logic          locked_q;
  logic          same;

  assign same = (mask_i == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= LK_IDLE;
      mask_q   <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (wr_i) begin
        mask_q <= mask_i;
        case (st_q)
          LK_ARM1: st_q <= (!key_i && same) ? LK_ARM0 : (key_i ? LK_ARM1 : LK_IDLE);
          LK_ARM0: st_q <= (key_i && same) ? LK_WAIT_RD : (key_i ? LK_ARM1 : LK_IDLE);
          default: st_q <= key_i ? LK_ARM1 : LK_IDLE;
        endcase
      end else if (rd_i && st_q == LK_WAIT_RD) begin
        locked_q <= 1'b1;
        st_q     <= LK_IDLE;
      end
    end
  end

  assign locked_o = locked_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_lock_pkg::*;
#(
  parameter int NP = N_PINS
) (
  input  logic [NP*FIELD_W-1:0] cfg_i,
  input  logic [NP-1:0]         odr_i,
  output logic [NP-1:0]         out_o,
  output logic [NP-1:0]         oe_o,
  output logic [NP-1:0]         od_o,
  output logic [NP-1:0]         pull_en_o,
  output logic [NP-1:0]         pull_up_o
);
  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic [1:0] mode, typ;
    assign mode         = cfg_i[FIELD_W*p +: 2];
    assign typ          = cfg_i[FIELD_W*p+2 +: 2];
    assign oe_o[p]      = (mode != 2'b00);
    assign out_o[p]     = oe_o[p] & odr_i[p];
    assign od_o[p]      = oe_o[p] & typ[0];
    assign pull_en_o[p] = !oe_o[p] && (typ == TYPE_PULL);
    assign pull_up_o[p] = pull_en_o[p] & odr_i[p];
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_od_o,
  output logic [N_PINS-1:0] pad_pull_en_o,
  output logic [N_PINS-1:0] pad_pull_up_o
);
  localparam int NP    = N_PINS;
  localparam int CFG_W = NP * FIELD_W;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_wdata;
  logic [NP-1:0]    cfg_we;
  logic [NP-1:0]    odr_q;
  logic [NP-1:0]    idr;
  logic [NP-1:0]    lock_mask;
  logic             locked;

  gpio_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (idr)
  );

  gpio_lock_ctrl #(.NP(NP)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && addr_i == A_LOCK),
    .rd_i    (re_i && addr_i == A_LOCK),
    .key_i   (wdata_i[KEY_BIT]),
    .mask_i  (wdata_i[NP-1:0]),
    .locked_o(locked),
    .mask_o  (lock_mask)
  );

  assign cfg_wdata = {wdata_i, wdata_i};

  for (genvar p = 0; p < NP; p++) begin : g_cfg_we
    localparam logic [ADDR_W-1:0] WORD = (p < PER_WORD) ? A_CFG_LO : A_CFG_HI;
    assign cfg_we[p] = we_i && (addr_i == WORD) && !(locked && lock_mask[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= {NP{FIELD_RST}};
    end else begin
      for (int p = 0; p < NP; p++)
        if (cfg_we[p]) cfg_q[FIELD_W*p +: FIELD_W] <= cfg_wdata[FIELD_W*p +: FIELD_W];
    end
  end

  // set half wins over clear half on the same pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odr_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_OUT:    odr_q <= wdata_i[NP-1:0];
        A_SETCLR: odr_q <= (odr_q & ~wdata_i[31:16]) | wdata_i[NP-1:0];
        A_CLR:    odr_q <= odr_q & ~wdata_i[NP-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG_LO: rdata_o = cfg_q[31:0];
      A_CFG_HI: rdata_o = cfg_q[63:32];
      A_IN:     rdata_o = {16'b0, idr};
      A_OUT:    rdata_o = {16'b0, odr_q};
      A_LOCK:   rdata_o = {15'b0, locked, lock_mask};
      default:  rdata_o = '0;
    endcase
  end

  gpio_pad_decode #(.NP(NP)) u_dec (
    .cfg_i    (cfg_q),
    .odr_i    (odr_q),
    .out_o    (pad_out_o),
    .oe_o     (pad_oe_o),
    .od_o     (pad_od_o),
    .pull_en_o(pad_pull_en_o),
    .pull_up_o(pad_pull_up_o)
  );
endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk
  import gpio_lock_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [63:0]       cfg_q,
  input logic [15:0]       odr_q,
  input logic              locked,
  input logic [15:0]       lock_mask,
  input logic [15:0]       oe,
  input logic [15:0]       od,
  input logic [15:0]       pull_en
);
  logic [63:0] frz;
  always_comb
    for (int p = 0; p < 16; p++) frz[4*p +: 4] = {4{lock_mask[p]}};

  a_r10_frozen_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ((cfg_q ^ $past(cfg_q)) & frz) == 64'b0);

  a_r12_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> (locked && $stable(lock_mask)));

  a_r9_lock_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked) |-> $past(re_i && addr_i == A_LOCK));

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SETCLR) |=> ((odr_q & $past(wdata_i[15:0])) == $past(wdata_i[15:0])));

  a_r3_od_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od & ~oe) == 16'b0);

  a_r4_pull_only_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en & oe) == 16'b0);
endmodule

bind gpio_lock_port gpio_lock_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .cfg_q    (cfg_q),
  .odr_q    (odr_q),
  .locked   (locked),
  .lock_mask(lock_mask),
  .oe       (pad_oe_o),
  .od       (pad_od_o),
  .pull_en  (pad_pull_en_o)
);

// File: tb/sim_gpio_lock_port.sv
module sim_gpio_lock_port;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0, re = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [15:0] pins = 0;
  logic [15:0] p_out, p_oe, p_od, p_pen, p_pup;

  int n_run = 0, n_fail = 0;

  // bench model
  logic [3:0]  m_cfg [16];
  logic [15:0] m_odr, m_mask, m_pins;
  logic        m_lk;
  int          m_st;

  always #(CLK_P/2) clk = ~clk;

  gpio_lock_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .pad_out_o(p_out), .pad_oe_o(p_oe), .pad_od_o(p_od),
    .pad_pull_en_o(p_pen), .pad_pull_up_o(p_pup)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic m_reset();
    for (int p = 0; p < 16; p++) m_cfg[p] = 4'h4;
    m_odr = 0; m_mask = 0; m_lk = 0; m_st = 0; m_pins = pins;
  endtask

  function automatic logic [79:0] exp_pads();
    logic [15:0] o, e, d, pe, pu;
    for (int p = 0; p < 16; p++) begin
      e[p]  = m_cfg[p][1:0] != 2'b00;
      o[p]  = e[p] & m_odr[p];
      d[p]  = e[p] & m_cfg[p][2];
      pe[p] = !e[p] && m_cfg[p][3:2] == 2'b10;
      pu[p] = pe[p] & m_odr[p];
    end
    return {o, e, d, pe, pu};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] r;
    r = 0;
    case (a)
      3'd0: for (int p = 0; p < 8; p++) r[4*p +: 4] = m_cfg[p];
      3'd1: for (int p = 0; p < 8; p++) r[4*p +: 4] = m_cfg[p+8];
      3'd2: r = {16'b0, m_pins};
      3'd3: r = {16'b0, m_odr};
      3'd6: r = {15'b0, m_lk, m_mask};
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic m_wr(input logic [2:0] a, input logic [31:0] d);
    logic key, same;
    case (a)
      3'd0: for (int p = 0; p < 8; p++) if (!(m_lk && m_mask[p])) m_cfg[p] = d[4*p +: 4];
      3'd1: for (int p = 8; p < 16; p++) if (!(m_lk && m_mask[p])) m_cfg[p] = d[4*(p-8) +: 4];
      3'd3: m_odr = d[15:0];
      3'd4: m_odr = (m_odr & ~d[31:16]) | d[15:0];
      3'd5: m_odr = m_odr & ~d[15:0];
      3'd6: if (!m_lk) begin
        key = d[16]; same = (d[15:0] == m_mask);
        if (m_st == 1)      m_st = (!key && same) ? 2 : (key ? 1 : 0);
        else if (m_st == 2) m_st = (key && same) ? 3 : (key ? 1 : 0);
        else                m_st = key ? 1 : 0;
        m_mask = d[15:0];
      end
      default: ;
    endcase
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    m_wr(a, d);
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 0;
    if (a == 3'd6 && !m_lk && m_st == 3) begin m_lk = 1; m_st = 0; end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a);
    logic [31:0] e, d;
    e = exp_rd(a);
    bus_rd(a, d);
    chk(req, {48'b0, d}, {48'b0, e});
  endtask

  task automatic chk_all(input string req);
    chk({req, " pads"}, {p_out, p_oe, p_od, p_pen, p_pup}, exp_pads());
    rd_chk({req, " cfg_lo"}, 3'd0);
    rd_chk({req, " cfg_hi"}, 3'd1);
    rd_chk({req, " odr"}, 3'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_all("R1");
    rd_chk("R1 lock", 3'd6);
    // R13 unmapped and write-only reads
    rd_chk("R13 addr7", 3'd7);
    rd_chk("R6 setclr reads 0", 3'd4);
    rd_chk("R7 clr reads 0", 3'd5);
    bus_wr(3'd7, 32'hFFFF_FFFF);
    chk_all("R13 write ignored");

    // R2/R3 field layout and output decode: pin 9 push-pull, pin 3 open-drain
    bus_wr(3'd1, 32'h4444_4414);
    bus_wr(3'd0, 32'h4444_5444);
    bus_wr(3'd3, 32'h0000_0208);
    chk_all("R2 R3 output decode");
    chk("R3 pin9 drives", {78'b0, p_oe[9], p_out[9]}, 80'd3);
    chk("R3 pin3 open-drain", {79'b0, p_od[3]}, 80'd1);
    bus_wr(3'd1, 32'h4444_4C4B);
    chk_all("R3 alternate types");

    // R4 pulls: pin0 up, pin1 down, pin2 analog
    bus_wr(3'd0, 32'h4444_4088);
    bus_wr(3'd3, 32'h0000_0001);
    chk_all("R4 pulls");
    chk("R4 pin0 up pin1 down", {76'b0, p_pen[1:0], p_pup[1:0]}, 80'b1101);

    // R6 set/clear: pin5 both -> set, pin6 clear, pin0 untouched
    bus_wr(3'd3, 32'h0000_0041);
    bus_wr(3'd4, 32'h0060_0020);
    chk("R6 set wins", {64'b0, m_odr}, {64'b0, 16'h0021});
    chk_all("R6 setclr");
    // R7 clear-only
    bus_wr(3'd5, 32'hFFFF_0001);
    chk_all("R7 clr");
    // R5 direct write
    bus_wr(3'd3, 32'hFFFF_A5C3);
    chk_all("R5 odr");

    // R8 synchronizer latency
    @(negedge clk); pins = 16'hA5A5; addr = 3'd2;
    @(negedge clk); #1 chk("R8 one edge old", {48'b0, rdata}, 80'h0);
    @(negedge clk); #1 chk("R8 two edges new", {48'b0, rdata}, {64'b0, 16'hA5A5});
    m_pins = pins;
    bus_wr(3'd2, 32'h0000_0000);
    rd_chk("R8 write ignored", 3'd2);

    // R11 broken sequences
    bus_wr(3'd6, 32'h0001_00F0);
    bus_wr(3'd6, 32'h0000_00F1);
    bus_wr(3'd6, 32'h0001_00F1);
    rd_chk("R11 changed mask", 3'd6);
    rd_chk("R11 not locked", 3'd6);
    bus_wr(3'd6, 32'h0001_00F0);
    bus_wr(3'd6, 32'h0000_00F0);
    rd_chk("R11 early read", 3'd6);
    bus_wr(3'd6, 32'h0000_00F0);
    rd_chk("R11 wrong key", 3'd6);

    // R9 full sequence: mask pins 4..7
    bus_wr(3'd6, 32'h0001_00F0);
    bus_wr(3'd6, 32'h0000_00F0);
    bus_wr(3'd6, 32'h0001_00F0);
    bus_rd(3'd6, d);
    chk("R9 completing read key 0", {48'b0, d}, {48'b0, 32'h0000_00F0});
    rd_chk("R9 locked", 3'd6);
    chk("R9 model locked", {79'b0, m_lk}, 80'd1);

    // R10 frozen fields, others writable
    bus_wr(3'd0, 32'h1111_1111);
    chk_all("R10 frozen");
    bus_wr(3'd3, 32'h0000_00F0);
    chk_all("R10 odr writable");

    // R12 lock register immutable
    bus_wr(3'd6, 32'h0000_FFFF);
    bus_wr(3'd6, 32'h0001_0F0F);
    rd_chk("R12 lock kept", 3'd6);

    // random mix against model
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  a;
      logic [31:0] w;
      a = 3'($urandom % 8);
      w = $urandom;
      if (a == 3'd6 && ($urandom % 4) != 0) a = 3'd4;
      bus_wr(a, w);
      chk("R3 R4 random pads", {p_out, p_oe, p_od, p_pen, p_pup}, exp_pads());
      rd_chk("R2 R5 R10 random read", 3'($urandom % 8));
    end

    // R1 second reset releases the lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_reset();
    chk_all("R1 after reset");
    rd_chk("R1 lock cleared", 3'd6);

    summary();
    $finish;
  end
endmodule